// File: doc/BRIEF.md
# Private Cache Retention and Snoop Wake Controller

This controller manages a private cache while the core is idle. On a sleep request from the power manager, it lowers only the data array to a programmable retention level. It then stops the cache clock and acknowledges the request. The tag and state arrays are never lowered, so the tag lookup can run while the data array is still recovering.

Snoop arrivals are flagged by detect logic that is always clocked. When a snoop arrives, the controller restarts the cache clock. In the next cycle it raises the data array to nominal and enables the tag access. A counter tracks the snoops that are still open. When the last one completes and sleep is still requested, the wake steps run backwards: the retention level is reapplied first, and the clock is gated after that.

Top module: `cache_sleep_ctrl`

## Requirements
- R1: After reset, `cache_clk_en`=1, `tag_en`=1, `data_sleep_code`=0, `sleep_ack`=0 and `underflow_err`=0.
- R2: Entry starts only while awake, with `sleep_req`=1, no snoop outstanding and no `snoop_valid` at that edge. One cycle later the code is applied, `tag_en`=0 and the clock is still on. One cycle after that, `cache_clk_en`=0 and `sleep_ack`=1.
- R3: `data_sleep_code` is a 3-bit field. 0 means nominal and 1..7 are the seven retention settings. It takes the `sleep_level` value sampled at the entry edge and reads 0 whenever `tag_en`=1.
- R4: A `snoop_valid` seen while asleep raises `cache_clk_en` in the next cycle, with the code still held and `tag_en`=0. One cycle later `tag_en`=1 and the code is 0.
- R5: When the outstanding count returns to zero and `sleep_req` is still high, the code is reapplied one cycle before the clock is gated.
- R6: A `snoop_valid` during the code-applied, clock-on cycle cancels re-entry. The next cycle is awake (`tag_en`=1, code 0), and the snoop is counted.
- R7: Each accepted `snoop_valid` adds one to the open count and each `snoop_done` takes one away; both in the same cycle leave the count unchanged. A `snoop_done` while the count is zero sets `underflow_err`, which stays set until reset.
- R8: `sleep_ack`=1 exactly when the clock is gated and the code is applied. Dropping `sleep_req` while asleep wakes the cache through the same two steps as R4.
- R9: While asleep with `sleep_req`=1 and no `snoop_valid`, the clock stays gated and the acknowledge stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Active-low reset |
| sleep_req | input | 1 | Retention request from the power manager |
| snoop_valid | input | 1 | Snoop arrival strobe from always-on detect logic |
| snoop_done | input | 1 | One outstanding snoop has been serviced |
| sleep_level | input | 3 | Retention setting, 0 = nominal |
| cache_clk_en | output | 1 | Cache domain clock enable |
| data_sleep_code | output | 3 | Retention code for the data array |
| tag_en | output | 1 | Tag/state access enable (cache ready) |
| sleep_ack | output | 1 | Cache gated and in retention (idle) |
| underflow_err | output | 1 | Sticky counter underflow flag |

## Verification
The bench uses the default counter width of three bits, so a burst of several snoops stays well below wraparound. The tests can therefore reach multi-snoop re-sleep, a snoop that lands exactly on the re-entry cycle, and an underflow. Levels 0, 5 and 7 are used, which covers the nominal code as a retention choice as well as the top setting.

// File: rtl/csw_pkg.sv
package csw_pkg;
    localparam int LVL_W = 3;

    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_ASLEEP = 2'd2,
        ST_UNGATE = 2'd3
    } csw_state_e;
endpackage

// File: rtl/csw_snoop_count.sv
module csw_snoop_count #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic snoop_valid,
    input  logic snoop_done,
    output logic none_left,
    output logic underflow_err
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             err;
    } cnt_reg_t;

    cnt_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (snoop_valid && !snoop_done) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end else if (snoop_done && !snoop_valid) begin
            if (r_q.cnt == '0) r_d.err = 1'b1;
            else               r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign none_left     = (r_q.cnt == '0);
    assign underflow_err = r_q.err;

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);
    assert_balanced_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && snoop_done) |=> $stable(none_left));
endmodule

// File: rtl/csw_seq.sv
module csw_seq
    import csw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             snoop_valid,
    input  logic             none_left,
    input  logic [LVL_W-1:0] sleep_level,
    output logic             cache_clk_en,
    output logic [LVL_W-1:0] data_sleep_code,
    output logic             tag_en,
    output logic             sleep_ack
);
    typedef struct packed {
        csw_state_e       st;
        logic [LVL_W-1:0] lvl;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_AWAKE: if (sleep_req && none_left && !snoop_valid) begin
                r_d.st  = ST_SETTLE;
                r_d.lvl = sleep_level;
            end
            ST_SETTLE: r_d.st = snoop_valid ? ST_AWAKE : ST_ASLEEP;
            ST_ASLEEP: if (snoop_valid || !sleep_req) r_d.st = ST_UNGATE;
            ST_UNGATE: r_d.st = ST_AWAKE;
            default:   r_d.st = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_AWAKE, lvl: '0};
        else        r_q <= r_d;
    end

    assign cache_clk_en    = (r_q.st != ST_ASLEEP);
    assign tag_en          = (r_q.st == ST_AWAKE);
    assign data_sleep_code = (r_q.st == ST_AWAKE) ? '0 : r_q.lvl;
    assign sleep_ack       = (r_q.st == ST_ASLEEP);

    assert_tag_after_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tag_en) |-> $past(cache_clk_en));
    assert_code_before_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cache_clk_en) |-> ($past(!tag_en) && $stable(data_sleep_code)));
    assert_wake_holds_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cache_clk_en) |-> (!tag_en && $stable(data_sleep_code)));
endmodule

// File: rtl/cache_sleep_ctrl.sv
module cache_sleep_ctrl #(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       snoop_valid,
    input  logic       snoop_done,
    input  logic [2:0] sleep_level,
    output logic       cache_clk_en,
    output logic [2:0] data_sleep_code,
    output logic       tag_en,
    output logic       sleep_ack,
    output logic       underflow_err
);
    logic none_left;

    csw_snoop_count #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .snoop_valid   (snoop_valid),
        .snoop_done    (snoop_done),
        .none_left     (none_left),
        .underflow_err (underflow_err)
    );

    csw_seq u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .sleep_req       (sleep_req),
        .snoop_valid     (snoop_valid),
        .none_left       (none_left),
        .sleep_level     (sleep_level),
        .cache_clk_en    (cache_clk_en),
        .data_sleep_code (data_sleep_code),
        .tag_en          (tag_en),
        .sleep_ack       (sleep_ack)
    );

    assert_ack_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ack |-> none_left);
    assert_gated_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_ack && sleep_req && !snoop_valid) |=> (sleep_ack && !cache_clk_en));
endmodule

// File: tb/cache_sleep_ctrl_test.sv
module cache_sleep_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0, snoop_valid = 1'b0, snoop_done = 1'b0;
    logic [2:0] sleep_level = 3'd0;
    logic       cache_clk_en, tag_en, sleep_ack, underflow_err;
    logic [2:0] data_sleep_code;

    int    n_checks = 0, n_fail = 0, cycles = 0;
    string cur_req = "R1";
    bit    done_run = 1'b0;

    // reference model state
    int m_phase = 0;   // 0 awake, 1 code applied, 2 gated, 3 clock back
    int m_open = 0;
    int m_lvl = 0;
    bit m_err = 1'b0;

    cache_sleep_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .snoop_valid(snoop_valid),
        .snoop_done(snoop_done), .sleep_level(sleep_level), .cache_clk_en(cache_clk_en),
        .data_sleep_code(data_sleep_code), .tag_en(tag_en), .sleep_ack(sleep_ack),
        .underflow_err(underflow_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_open = 0; m_lvl = 0; m_err = 1'b0;
        end else begin
            int nxt;
            nxt = m_phase;
            if (m_phase == 0 && sleep_req && m_open == 0 && !snoop_valid) begin
                nxt = 1; m_lvl = int'(sleep_level);
            end else if (m_phase == 1) nxt = snoop_valid ? 0 : 2;
            else if (m_phase == 2 && (snoop_valid || !sleep_req)) nxt = 3;
            else if (m_phase == 3) nxt = 0;
            m_phase = nxt;
            if (snoop_valid && !snoop_done) m_open++;
            else if (snoop_done && !snoop_valid) begin
                if (m_open == 0) m_err = 1'b1; else m_open--;
            end
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            check(cur_req, {7'd0, cache_clk_en}, {7'd0, m_phase != 2}, "cache_clk_en");
            check(cur_req, {7'd0, tag_en}, {7'd0, m_phase == 0}, "tag_en");
            check(cur_req, {5'd0, data_sleep_code}, (m_phase == 0) ? 8'd0 : 8'(m_lvl), "data_sleep_code");
            check(cur_req, {7'd0, sleep_ack}, {7'd0, m_phase == 2}, "sleep_ack");
            check(cur_req, {7'd0, underflow_err}, {7'd0, m_err}, "underflow_err");
        end
    end

    task automatic step(bit rq, bit v, bit d, logic [2:0] lv);
        sleep_req = rq; snoop_valid = v; snoop_done = d; sleep_level = lv;
        @(negedge clk);
    endtask

    task automatic idle(bit rq, logic [2:0] lv, int n);
        for (int i = 0; i < n; i++) step(rq, 1'b0, 1'b0, lv);
    endtask

    task automatic finish_run();
        done_run = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000 && !done_run) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<=5000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1", {5'd0, data_sleep_code}, 8'd0, "reset code");
        check("R1", {7'd0, tag_en}, 8'd1, "reset tag_en");

        cur_req = "R2";                           // entry at level 5
        step(1'b1, 1'b0, 1'b0, 3'd5);
        check("R2", {7'd0, cache_clk_en}, 8'd1, "clock on while code applied");
        check("R3", {5'd0, data_sleep_code}, 8'd5, "latched level");
        idle(1'b1, 3'd2, 1);                      // level change after entry ignored
        check("R2", {7'd0, sleep_ack}, 8'd1, "ack after gating");
        check("R3", {5'd0, data_sleep_code}, 8'd5, "level not resampled");

        cur_req = "R9";
        idle(1'b1, 3'd2, 6);
        check("R9", {7'd0, cache_clk_en}, 8'd0, "stays gated");

        cur_req = "R4";                           // single snoop wake
        step(1'b1, 1'b1, 1'b0, 3'd7);
        check("R4", {7'd0, cache_clk_en}, 8'd1, "clock first");
        check("R4", {7'd0, tag_en}, 8'd0, "tag waits");
        idle(1'b1, 3'd7, 1);
        check("R4", {7'd0, tag_en}, 8'd1, "tag second cycle");
        check("R3", {5'd0, data_sleep_code}, 8'd0, "nominal while tag");
        idle(1'b1, 3'd7, 3);
        check("R7", {7'd0, sleep_ack}, 8'd0, "no sleep while open");

        cur_req = "R5";
        step(1'b1, 1'b0, 1'b1, 3'd7);
        idle(1'b1, 3'd7, 1);
        check("R5", {5'd0, data_sleep_code}, 8'd7, "code reapplied");
        check("R5", {7'd0, cache_clk_en}, 8'd1, "clock still on");
        idle(1'b1, 3'd7, 1);
        check("R5", {7'd0, cache_clk_en}, 8'd0, "then gated");

        cur_req = "R7";                           // burst of three, one pair balanced
        step(1'b1, 1'b1, 1'b0, 3'd3);
        step(1'b1, 1'b1, 1'b0, 3'd3);
        step(1'b1, 1'b1, 1'b1, 3'd3);
        step(1'b1, 1'b1, 1'b0, 3'd3);
        idle(1'b1, 3'd3, 2);
        step(1'b1, 1'b0, 1'b1, 3'd3);
        step(1'b1, 1'b0, 1'b1, 3'd3);
        idle(1'b1, 3'd3, 2);
        check("R7", {7'd0, sleep_ack}, 8'd0, "one still open");

        cur_req = "R6";                           // last done, then snoop on re-entry cycle
        step(1'b1, 1'b0, 1'b1, 3'd3);
        step(1'b1, 1'b0, 1'b0, 3'd3);
        check("R6", {5'd0, data_sleep_code}, 8'd3, "in re-entry");
        step(1'b1, 1'b1, 1'b0, 3'd3);
        check("R6", {7'd0, tag_en}, 8'd1, "aborted to awake");
        idle(1'b1, 3'd3, 3);
        check("R6", {7'd0, sleep_ack}, 8'd0, "snoop kept open");
        step(1'b1, 1'b0, 1'b1, 3'd0);
        idle(1'b1, 3'd0, 4);
        check("R3", {7'd0, sleep_ack}, 8'd1, "level 0 still gates");

        cur_req = "R8";
        step(1'b0, 1'b0, 1'b0, 3'd0);
        check("R8", {7'd0, sleep_ack}, 8'd0, "release drops ack");
        check("R8", {7'd0, cache_clk_en}, 8'd1, "clock back");
        idle(1'b0, 3'd0, 2);
        check("R8", {7'd0, tag_en}, 8'd1, "awake");

        cur_req = "R7";                           // underflow
        step(1'b0, 1'b0, 1'b1, 3'd0);
        check("R7", {7'd0, underflow_err}, 8'd1, "underflow flagged");
        idle(1'b0, 3'd0, 3);
        check("R7", {7'd0, underflow_err}, 8'd1, "underflow sticky");

        cur_req = "R2";                           // snoop at entry edge blocks entry
        step(1'b1, 1'b1, 1'b0, 3'd6);
        check("R2", {7'd0, tag_en}, 8'd1, "entry blocked by snoop");
        step(1'b1, 1'b0, 1'b1, 3'd6);
        idle(1'b1, 3'd6, 3);
        check("R2", {7'd0, sleep_ack}, 8'd1, "entry after done");

        finish_run();
    end
endmodule